// File: doc/BRIEF.md
# Broadcast Message Bus Initiator

This block is a bus master that sends one broadcast message over a 32-bit multiplexed address/data bus using the Special Cycle command. No target is addressed and none claims the transfer. The block does not arbitrate. When the grant input is high, it accepts a request that carries a 16-bit message code and 16 bits of message-dependent data. It then runs an address phase that carries only the command, followed by a single full-word data phase.

Because no agent answers with DEVSEL#, the initiator keeps IRDY# low for the whole selection window and then ends the transfer with a master abort. After the abort it returns the bus through a turnaround clock. A completion pulse and an abort flag tell the user side how the transfer ended. A built-in passive monitor watches the bus lines the initiator drives and shows the message the way a listening target would capture it.

Codes 0, 1 and 2 mean shutdown, halt and a processor-specific message. Every other code is reserved, but the block passes it through without change.

Top module: `bcast_cycle_initiator`

## Requirements
- R1: One clock after `req_i` and `gnt_i` are both high in idle, the address phase appears for exactly one clock. In it, `frame_no` is 0, `cbe_no` is 4'b0001 (the Special Cycle command), `ad_o` is driven to 0 with `ad_oe_o` high, and `irdy_no` is 1.
- R2: On the clock after the address phase, `frame_no` is 1 and `irdy_no` is 0. `ad_o[15:0]` holds the captured code and `ad_o[31:16]` holds the captured data. Every code value from 0x0000 to 0xFFFF, reserved ones included, appears unchanged.
- R3: `cbe_no` is 4'b0000 (all bytes enabled) on every clock in which `irdy_no` is 0.
- R4: On the clock after each clock with `ad_oe_o` high, `par_oe_o` is high and `par_o` equals the XOR of that earlier clock's `ad_o` and `cbe_no`, which is even parity. `par_oe_o` is low otherwise.
- R5: If `devsel_ni` is never sampled low, `irdy_no` stays low for exactly DEVSEL_WAIT (4) clocks. The next clock then has `irdy_no` high, `done_o` high and `abort_o` high. From the address phase through that clock the transfer spans six clocks.
- R6: If `devsel_ni` is sampled low on any data-phase clock, the next clock has `irdy_no` high, `done_o` high and `abort_o` low.
- R7: After `irdy_no` rises, `ad_oe_o` is low. At least one further clock passes with `frame_no` and `irdy_no` both high before the next address phase, even if `req_i` stays high.
- R8: While `gnt_i` is low, no transfer starts. A request or new code/data presented while busy does not change the message being sent.
- R9: `mon_valid_o` is high for exactly one clock: the first clock with `irdy_no` low after a Special Cycle address phase. In that clock `mon_code_o` and `mon_data_o` equal `ad_o[15:0]` and `ad_o[31:16]`.
- R10: After reset, `frame_no` and `irdy_no` are 1, and `ad_oe_o`, `par_oe_o`, `busy_o`, `done_o` and `mon_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request to send a message |
| gnt_i | input | 1 | Bus grant, active high |
| code_i | input | 16 | Message code |
| data_i | input | 16 | Message-dependent data |
| devsel_ni | input | 1 | Target claim, active low |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-clock completion pulse |
| abort_o | output | 1 | Transfer ended by master abort (valid with done_o) |
| frame_no | output | 1 | FRAME#, active low |
| irdy_no | output | 1 | IRDY#, active low |
| cbe_no | output | 4 | Command / byte enables, active low |
| ad_o | output | 32 | Address/data bus value |
| ad_oe_o | output | 1 | Drive enable for ad_o and cbe_no |
| par_o | output | 1 | Even parity of the previous phase |
| par_oe_o | output | 1 | Drive enable for par_o |
| mon_valid_o | output | 1 | Monitor captured a message |
| mon_code_o | output | 16 | Captured message code |
| mon_data_o | output | 16 | Captured message data |

## Verification
If the state register or the message latch went wrong, the bus lines would show it within one clock of the request. The address phase would be missing, or the wrong command would appear on `cbe_no`, or `ad_o` would carry the wrong code, and the monitor pulse would repeat the error in that same clock. A wrong selection-window counter shows up only at the end of the transfer, as an IRDY# run that is not four clocks long, a turnaround clock that comes early or late, or a wrong `abort_o`. A parity fault shows one clock after the phase it covers. The sweep therefore checks every bus line on every clock of each transfer and tries a claim on each of the four data-phase clocks.

// File: rtl/bci_pkg.sv
package bci_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_TURN = 2'd3
  } bci_state_e;

  localparam logic [3:0] CMD_SPECIAL = 4'b0001;
  localparam logic [3:0] BE_ALL_N    = 4'b0000;
  localparam logic [3:0] CBE_IDLE    = 4'b1111;
endpackage

// File: rtl/bci_parity.sv
module bci_parity #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_ni,
  input  logic             oe_i,
  output logic             par_o,
  output logic             par_oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_o    <= 1'b0;
      par_oe_o <= 1'b0;
    end else begin
      par_o    <= oe_i ? ^{ad_i, cbe_ni} : 1'b0;
      par_oe_o <= oe_i;
    end
  end

  assert_par_follows_phase_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |=> par_oe_o);
  assert_par_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |=> !par_oe_o);
endmodule

// File: rtl/bci_monitor.sv
module bci_monitor
  import bci_pkg::*;
#(
  parameter int MSG_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_ni,
  input  logic               irdy_ni,
  input  logic [3:0]         cbe_ni,
  input  logic [2*MSG_W-1:0] ad_i,
  output logic               valid_o,
  output logic [MSG_W-1:0]   code_o,
  output logic [MSG_W-1:0]   data_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              armed_q <= 1'b0;
    else if (!frame_ni && cbe_ni == CMD_SPECIAL) armed_q <= 1'b1;
    else if (!irdy_ni)                        armed_q <= 1'b0;
  end

  assign valid_o = armed_q && !irdy_ni;
  assign code_o  = ad_i[MSG_W-1:0];
  assign data_o  = ad_i[2*MSG_W-1:MSG_W];

  assert_mon_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_mon_on_irdy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !irdy_ni && $past(!frame_ni));
endmodule

// File: rtl/bci_fsm.sv
module bci_fsm
  import bci_pkg::*;
#(
  parameter int MSG_W       = 16,
  parameter int DEVSEL_WAIT = 4,
  localparam int CNT_W      = $clog2(DEVSEL_WAIT + 1),
  localparam int AD_W       = 2 * MSG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             gnt_i,
  input  logic [MSG_W-1:0] code_i,
  input  logic [MSG_W-1:0] data_i,
  input  logic             devsel_ni,
  output logic             frame_no,
  output logic             irdy_no,
  output logic [3:0]       cbe_no,
  output logic [AD_W-1:0]  ad_o,
  output logic             ad_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             abort_o
);
  bci_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [AD_W-1:0]  msg_q;
  logic             abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      msg_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i && gnt_i) begin
          msg_q   <= {data_i, code_i};
          state_q <= ST_ADDR;
        end
        ST_ADDR: begin
          cnt_q   <= '0;
          state_q <= ST_DATA;
        end
        ST_DATA: begin
          if (!devsel_ni) begin
            abort_q <= 1'b0;
            state_q <= ST_TURN;
          end else if (cnt_q == CNT_W'(DEVSEL_WAIT - 1)) begin
            abort_q <= 1'b1;
            state_q <= ST_TURN;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    frame_no = (state_q != ST_ADDR);
    irdy_no  = (state_q != ST_DATA);
    ad_oe_o  = (state_q == ST_ADDR) || (state_q == ST_DATA);
    ad_o     = (state_q == ST_DATA) ? msg_q : '0;
    unique case (state_q)
      ST_ADDR: cbe_no = CMD_SPECIAL;
      ST_DATA: cbe_no = BE_ALL_N;
      default: cbe_no = CBE_IDLE;
    endcase
    busy_o  = (state_q != ST_IDLE);
    done_o  = (state_q == ST_TURN);
    abort_o = (state_q == ST_TURN) && abort_q;
  end

  // checker: length of the current IRDY# low run
  logic [CNT_W:0] irdy_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irdy_run_q <= '0;
    else if (!irdy_no) irdy_run_q <= irdy_run_q + 1'b1;
    else               irdy_run_q <= '0;
  end

  assert_data_after_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irdy_no) |-> frame_no && $past(!frame_no));
  assert_full_be_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irdy_no |-> cbe_no == 4'b0000);
  assert_abort_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && abort_o) |-> irdy_run_q == (CNT_W+1)'(DEVSEL_WAIT));
  assert_claim_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irdy_no && !devsel_ni) |=> done_o && !abort_o && irdy_no);
  assert_gap_before_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_no) |-> irdy_no && $past(irdy_no) && $past(frame_no));
  assert_release_after_irdy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irdy_no) |-> !ad_oe_o);
  assert_no_start_without_gnt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !gnt_i) |=> frame_no);
  assert_msg_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irdy_no && $past(!irdy_no)) |-> $stable(ad_o));
endmodule

// File: rtl/bcast_cycle_initiator.sv
module bcast_cycle_initiator #(
  parameter int MSG_W       = 16,
  parameter int DEVSEL_WAIT = 4,
  localparam int AD_W       = 2 * MSG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             gnt_i,
  input  logic [MSG_W-1:0] code_i,
  input  logic [MSG_W-1:0] data_i,
  input  logic             devsel_ni,
  output logic             busy_o,
  output logic             done_o,
  output logic             abort_o,
  output logic             frame_no,
  output logic             irdy_no,
  output logic [3:0]       cbe_no,
  output logic [AD_W-1:0]  ad_o,
  output logic             ad_oe_o,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             mon_valid_o,
  output logic [MSG_W-1:0] mon_code_o,
  output logic [MSG_W-1:0] mon_data_o
);
  bci_fsm #(.MSG_W(MSG_W), .DEVSEL_WAIT(DEVSEL_WAIT)) u_fsm (
    .clk_i, .rst_ni, .req_i, .gnt_i, .code_i, .data_i, .devsel_ni,
    .frame_no, .irdy_no, .cbe_no, .ad_o, .ad_oe_o,
    .busy_o, .done_o, .abort_o
  );

  bci_parity #(.AD_W(AD_W), .CBE_W(4)) u_par (
    .clk_i, .rst_ni, .ad_i(ad_o), .cbe_ni(cbe_no), .oe_i(ad_oe_o),
    .par_o, .par_oe_o
  );

  bci_monitor #(.MSG_W(MSG_W)) u_mon (
    .clk_i, .rst_ni, .frame_ni(frame_no), .irdy_ni(irdy_no), .cbe_ni(cbe_no),
    .ad_i(ad_o), .valid_o(mon_valid_o), .code_o(mon_code_o), .data_o(mon_data_o)
  );

  assert_addr_phase_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_no |-> cbe_no == 4'b0001 && ad_oe_o && irdy_no);
  assert_even_parity_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_oe_o |-> par_o == $past(^{ad_o, cbe_no}));
  assert_mon_matches_bus_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mon_valid_o |-> {mon_data_o, mon_code_o} == ad_o);
endmodule

// File: tb/bcast_cycle_initiator_bench.sv
module bcast_cycle_initiator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, gnt = 1'b0, devsel_n = 1'b1;
  logic [15:0] code = '0, data = '0;
  logic        busy, done, abort_f, frame_n, irdy_n, ad_oe, par, par_oe;
  logic [3:0]  cbe_n;
  logic [31:0] ad;
  logic        mon_valid;
  logic [15:0] mon_code, mon_data;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bcast_cycle_initiator u_bcast_cycle_initiator (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .gnt_i(gnt), .code_i(code),
    .data_i(data), .devsel_ni(devsel_n), .busy_o(busy), .done_o(done),
    .abort_o(abort_f), .frame_no(frame_n), .irdy_no(irdy_n), .cbe_no(cbe_n),
    .ad_o(ad), .ad_oe_o(ad_oe), .par_o(par), .par_oe_o(par_oe),
    .mon_valid_o(mon_valid), .mon_code_o(mon_code), .mon_data_o(mon_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // one transfer; claim_at < 0 means no target claims it
  task automatic run_msg(input logic [15:0] c, input logic [15:0] d, input int claim_at,
                         input bit poke_busy);
    logic [31:0] exp_ad;
    logic        exp_par;
    int          ndata;
    exp_ad = {d, c};
    req = 1'b1; gnt = 1'b1; code = c; data = d;
    @(negedge clk);
    req = 1'b0; code = ~c; data = ~d;
    chk("R1 frame", frame_n, 0);
    chk("R1 cmd", cbe_n, 4'b0001);
    chk("R1 ad", {ad_oe, ad[30:0]}, {1'b1, 31'h0});
    chk("R1 irdy", irdy_n, 1);
    ndata = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      ndata++;
      chk("R2 irdy", {frame_n, irdy_n}, 2'b10);
      chk("R2 msg", ad, exp_ad);
      chk("R3 be", cbe_n, 4'b0000);
      if (i == 0) begin
        chk("R4 addr parity", {par_oe, par}, {1'b1, 1'b1});
        chk("R9 mon", {mon_valid, mon_data, mon_code}, {1'b1, exp_ad});
      end else begin
        chk("R9 single", mon_valid, 0);
        chk("R8 busy req ignored", ad, exp_ad);
      end
      if (poke_busy && i == 1) begin
        req = 1'b1; code = 16'h5A5A; data = 16'hC3C3;
      end
      if (poke_busy && i == 2) req = 1'b0;
      if (claim_at == i) begin
        devsel_n = 1'b0;
        break;
      end
    end
    exp_par = ^{exp_ad, 4'b0000};
    @(negedge clk);
    devsel_n = 1'b1;
    if (claim_at < 0) begin
      chk("R5 ndata", ndata, 4);
      chk("R5 end", {done, abort_f, irdy_n}, 3'b111);
    end else begin
      chk("R6 ndata", ndata, claim_at + 1);
      chk("R6 end", {done, abort_f, irdy_n}, 3'b101);
    end
    chk("R4 data parity", {par_oe, par}, {1'b1, exp_par});
    chk("R7 release", {ad_oe, frame_n}, 2'b01);
    @(negedge clk);
    chk("R7 idle", {frame_n, irdy_n, busy, done}, 4'b1100);
    chk("R4 par off", par_oe, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      summary();
    end
  end

  initial begin
    logic [15:0] c, d;
    @(negedge clk);
    chk("R10 reset", {frame_n, irdy_n, ad_oe, par_oe, busy, done, mon_valid}, 7'b1100000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after release", {frame_n, irdy_n, busy}, 3'b110);

    // no grant: request must wait
    req = 1'b1; gnt = 1'b0; code = 16'h0001;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 no gnt", {frame_n, busy, ad_oe}, 3'b100);
    end
    req = 1'b0;
    @(negedge clk);

    // sweep of codes, including defined and reserved
    for (int k = 0; k < 24; k++) begin
      case (k)
        0, 1, 2, 3: c = 16'(k);
        4:          c = 16'hFFFF;
        5:          c = 16'h8000;
        default:    c = 16'(k * 16'h1357) ^ 16'hA5A5;
      endcase
      d = 16'(k * 16'h0F0F + 16'h0101);
      run_msg(c, d, -1, (k == 6));
    end

    // claim on each data clock
    for (int a = 0; a < 4; a++) run_msg(16'h0002, 16'(16'h1111 * (a + 1)), a, 0);

    // back-to-back with request held high
    req = 1'b1; gnt = 1'b1; code = 16'h0000; data = 16'hBEEF;
    @(negedge clk);
    chk("R1 b2b first", frame_n, 0);
    repeat (4) @(negedge clk);
    @(negedge clk);
    chk("R5 b2b abort", {done, abort_f}, 2'b11);
    @(negedge clk);
    chk("R7 gap", {frame_n, irdy_n}, 2'b11);
    @(negedge clk);
    chk("R7 next frame", frame_n, 0);
    req = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 settled", {busy, frame_n}, 2'b01);

    finished = 1;
    summary();
  end
endmodule